// File: doc/BRIEF.md
# Burst Serial Audio Format Converter

This block turns a stereo serial audio stream whose framing clock arrives in bursts, with the left and right channels on separate data lines, into one continuous MSB-first, right-justified stream that a digital audio transmitter can accept. Its three outputs are a bit clock, a word clock that marks the two channel halves, and one data line.

The whole block runs from the transmitter's master clock. All source lines are brought into that domain through two-flop synchronisers, and their edges are found by comparing each line with its previous value. A divide-by-four of the master clock is driven back out to run the upstream decoder. The output bit clock is the source bit clock divided by a parameter. The right channel goes through a shift register one word long, so that it comes out in the half-frame after the matching left word. A word counter, restarted by the first framing edge after a quiet gap, rebuilds the word clock. If no burst arrives, the counter runs on unchanged, so the receiver stays locked.

Top module: `burst_audio_conv`

## Requirements
- R1: `mclkDiv4` is the master clock divided by four, with two cycles high and two cycles low. It is low during reset, and after reset is released it reads `(k>>1)&1` after k master-clock edges.
- R2: `bck` is the synchronised `srcBitClk` divided by DIV (default 2). The first synchronised source rising edge of each pair raises `bck`, and the second one, called the bit tick, lowers it.
- R3: A rising edge on `frameClk` starts a burst only when at least GAP (default 16) master-clock cycles have passed since the previous rising edge of `frameClk`. Edges that come closer together are ignored. The first edge after reset always counts.
- R4: A burst start sets `wck` high and restarts the word count, so the next WORD (default 24) bit ticks form the left half-frame.
- R5: After a burst, `wck` toggles once every WORD bit ticks. It keeps doing so with no further bursts.
- R6: `dataOut` and `wck` change only at a bit tick or a burst start, never between them.
- R7: At a bit tick where `wck` was high, `dataOut` takes the `leftIn` value captured at the source edge that made the tick.
- R8: At a bit tick where `wck` was low, `dataOut` takes the `rightIn` value captured WORD bit ticks earlier. Positions that were never filled read 0.
- R9: Synchronous active-low reset `rstN` clears `bck`, `wck`, `dataOut`, `mclkDiv4` and the delay line. After reset, `wck` and `dataOut` stay low until the first burst is detected, even while bit ticks occur.
- R10: A burst that arrives in the middle of a half-frame restarts the frame at once, with `wck` high and a fresh count of WORD left bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, also used by the transmitter |
| rstN | input | 1 | Synchronous reset, active low |
| srcBitClk | input | 1 | Source bit clock |
| leftIn | input | 1 | Source left-channel serial data |
| rightIn | input | 1 | Source right-channel serial data |
| frameClk | input | 1 | Source framing clock that arrives in bursts |
| mclkDiv4 | output | 1 | Master clock divided by four, for the source chipset |
| bck | output | 1 | Output bit clock |
| wck | output | 1 | Output word clock; high marks the left half-frame |
| dataOut | output | 1 | Multiplexed serial data, updated on the falling edge of `bck` |

## Verification
The hardest case to reach from the ports is a burst that lands in the middle of a half-frame while the delay line still holds right samples from the old frame. A restart then has to reset the word count without touching the delay line. The stimulus table puts bursts at bit offsets that are not multiples of the word length, runs long segments with no burst so the counter free-runs across several frames, and drives several framing edges inside each burst to check that the edges closer than the gap are rejected. A reset in mid-stream followed by bit ticks with no burst shows that the outputs stay low until a new burst arrives.

// File: rtl/burst_audio_pkg.sv
package burst_audio_pkg;
  typedef struct packed {
    logic shiftEn;   // bit tick while framing is active
    logic selLeft;   // word clock before this tick
  } convStrobes_t;
endpackage

// File: rtl/burst_audio_ctrl.sv
module burst_audio_ctrl
  import burst_audio_pkg::*;
#(
  parameter int DIV  = 2,
  parameter int WORD = 24,
  parameter int GAP  = 16
) (
  input  logic         mclk,
  input  logic         rstN,
  input  logic         srcBitClk,
  input  logic         frameClk,
  output logic         mclkDiv4,
  output logic         bck,
  output logic         wck,
  output convStrobes_t strb
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int CW = $clog2(WORD);
  localparam int IW = $clog2(GAP + 1);

  logic [1:0]    divCnt;
  logic          srcS1, srcS2, srcPrev;
  logic          frmS1, frmS2, frmPrev;
  logic [PW-1:0] phCnt;
  logic [IW-1:0] idleCnt;
  logic [CW-1:0] wordCnt;
  logic          started;
  logic          srcRise, frmRise, tickRaw, burstStart;

  assign srcRise    = srcS2 & ~srcPrev;
  assign frmRise    = frmS2 & ~frmPrev;
  assign tickRaw    = srcRise && (phCnt == PW'(DIV - 1));
  assign burstStart = frmRise && (idleCnt >= IW'(GAP));
  assign mclkDiv4   = divCnt[1];

  always_ff @(posedge mclk) begin
    if (!rstN) begin
      divCnt <= '0;
      {srcS1, srcS2, srcPrev} <= '0;
      {frmS1, frmS2, frmPrev} <= '0;
    end else begin
      divCnt  <= divCnt + 2'd1;
      srcS1   <= srcBitClk;
      srcS2   <= srcS1;
      srcPrev <= srcS2;
      frmS1   <= frameClk;
      frmS2   <= frmS1;
      frmPrev <= frmS2;
    end
  end

  // bit phase and output bit clock
  always_ff @(posedge mclk) begin
    if (!rstN) begin
      phCnt <= '0;
      bck   <= 1'b0;
    end else if (srcRise) begin
      if (phCnt == PW'(DIV - 1)) begin
        phCnt <= '0;
        bck   <= 1'b0;
      end else begin
        phCnt <= phCnt + PW'(1);
        if (phCnt == PW'(DIV / 2 - 1)) bck <= 1'b1;
      end
    end
  end

  // quiet-gap measurement on the framing line
  always_ff @(posedge mclk) begin
    if (!rstN)                     idleCnt <= IW'(GAP);
    else if (frmRise)              idleCnt <= '0;
    else if (idleCnt < IW'(GAP))   idleCnt <= idleCnt + IW'(1);
  end

  // word counter and word clock
  always_ff @(posedge mclk) begin
    if (!rstN) begin
      wordCnt <= '0;
      wck     <= 1'b0;
      started <= 1'b0;
    end else if (burstStart) begin
      wordCnt <= '0;
      wck     <= 1'b1;
      started <= 1'b1;
    end else if (tickRaw && started) begin
      if (wordCnt == CW'(WORD - 1)) begin
        wordCnt <= '0;
        wck     <= ~wck;
      end else begin
        wordCnt <= wordCnt + CW'(1);
      end
    end
  end

  always_comb begin
    strb.shiftEn = tickRaw && started && !burstStart;
    strb.selLeft = wck;
  end

  // R6
  wck_change_chk: assert property (@(posedge mclk) disable iff (!rstN)
    (wck != $past(wck)) |-> $past(tickRaw || burstStart));
  // R5
  word_bound_chk: assert property (@(posedge mclk) disable iff (!rstN)
    wordCnt <= CW'(WORD - 1));
  // R4
  burst_restart_chk: assert property (@(posedge mclk) disable iff (!rstN)
    burstStart |=> (wck && wordCnt == '0));
  // R9
  idle_low_chk: assert property (@(posedge mclk) disable iff (!rstN)
    !started |-> !wck);
endmodule

// File: rtl/burst_audio_dp.sv
module burst_audio_dp
  import burst_audio_pkg::*;
#(
  parameter int WORD = 24
) (
  input  logic         mclk,
  input  logic         rstN,
  input  logic         leftIn,
  input  logic         rightIn,
  input  convStrobes_t strb,
  output logic         dataOut
);
  logic            lS1, lS2, rS1, rS2;
  logic [WORD-1:0] rightDly;

  always_ff @(posedge mclk) begin
    if (!rstN) begin
      {lS1, lS2, rS1, rS2} <= '0;
    end else begin
      lS1 <= leftIn;
      lS2 <= lS1;
      rS1 <= rightIn;
      rS2 <= rS1;
    end
  end

  always_ff @(posedge mclk) begin
    if (!rstN) begin
      rightDly <= '0;
      dataOut  <= 1'b0;
    end else if (strb.shiftEn) begin
      rightDly <= {rightDly[WORD-2:0], rS2};
      dataOut  <= strb.selLeft ? lS2 : rightDly[WORD-1];
    end
  end

  // R6
  data_hold_chk: assert property (@(posedge mclk) disable iff (!rstN)
    !strb.shiftEn |=> $stable(dataOut));
endmodule

// File: rtl/burst_audio_conv.sv
module burst_audio_conv
  import burst_audio_pkg::*;
#(
  parameter int DIV  = 2,
  parameter int WORD = 24,
  parameter int GAP  = 16
) (
  input  logic mclk,
  input  logic rstN,
  input  logic srcBitClk,
  input  logic leftIn,
  input  logic rightIn,
  input  logic frameClk,
  output logic mclkDiv4,
  output logic bck,
  output logic wck,
  output logic dataOut
);
  convStrobes_t strb;

  burst_audio_ctrl #(.DIV(DIV), .WORD(WORD), .GAP(GAP)) ctrl (
    .mclk(mclk), .rstN(rstN), .srcBitClk(srcBitClk), .frameClk(frameClk),
    .mclkDiv4(mclkDiv4), .bck(bck), .wck(wck), .strb(strb));

  burst_audio_dp #(.WORD(WORD)) dp (
    .mclk(mclk), .rstN(rstN), .leftIn(leftIn), .rightIn(rightIn),
    .strb(strb), .dataOut(dataOut));
endmodule

// File: tb/burst_audio_conv_test.sv
module burst_audio_conv_test;
  localparam int CLK_PERIOD = 10;
  localparam int WORD = 24;
  // segment: [56] burst, [55:48] bits, [47:24] left pattern, [23:0] right pattern
  localparam logic [56:0] SEGS [5] = '{
    {1'b1, 8'd60, 24'hA5C3F0, 24'h0F1E2D},
    {1'b0, 8'd50, 24'h123456, 24'hFEDCBA},
    {1'b1, 8'd30, 24'h800001, 24'h7FFFFE},
    {1'b0, 8'd40, 24'hFFFFFF, 24'h000000},
    {1'b1, 8'd48, 24'h000000, 24'hFFFFFF}
  };

  logic mclk = 1'b0, rstN = 1'b0;
  logic srcBitClk = 1'b0, leftIn = 1'b0, rightIn = 1'b0, frameClk = 1'b0;
  logic mclkDiv4, bck, wck, dataOut;
  int checks = 0, fails = 0, cycles = 0;

  logic mStarted = 1'b0, mWck = 1'b0;
  int mCnt = 0;
  logic [WORD-1:0] rq = '0;

  burst_audio_conv uut (.mclk(mclk), .rstN(rstN), .srcBitClk(srcBitClk),
    .leftIn(leftIn), .rightIn(rightIn), .frameClk(frameClk),
    .mclkDiv4(mclkDiv4), .bck(bck), .wck(wck), .dataOut(dataOut));

  always #(CLK_PERIOD / 2) mclk = ~mclk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge mclk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  // one output bit = two source periods of 8 master cycles
  task automatic driveBit(input logic l, input logic r, input logic frameOn, input logic newBurst);
    logic exp;
    for (int off = 0; off < 16; off++) begin
      @(negedge mclk);
      srcBitClk = (off % 8) < 4;
      frameClk  = frameOn && ((off % 8) >= 4);
      if (off == 0) begin leftIn = l; rightIn = r; end
      if (off == 7) check(bck == 1'b1, "R2 bck high", int'(bck), 1);
      if (off == 15) begin
        check(bck == 1'b0, "R2 bck low", int'(bck), 0);
        if (newBurst) begin mStarted = 1'b1; mWck = 1'b1; mCnt = 0; end
        exp = 1'b0;
        if (mStarted) begin
          exp = mWck ? l : rq[WORD-1];
          rq = {rq[WORD-2:0], r};
          if (mCnt == WORD - 1) begin mCnt = 0; mWck = ~mWck; end
          else mCnt++;
        end
        if (mWck) check(dataOut == exp, "R7 left data", int'(dataOut), int'(exp));
        else      check(dataOut == exp, "R8 delayed right data", int'(dataOut), int'(exp));
        check(wck == mWck, "R5 wck", int'(wck), int'(mWck));
      end
    end
  endtask

  initial begin
    logic [56:0] s;
    repeat (3) @(negedge mclk);
    // R9 reset state
    check({bck, wck, dataOut, mclkDiv4} == 4'b0, "R9 reset outputs", int'({bck, wck, dataOut, mclkDiv4}), 0);
    rstN = 1'b1;
    // R1 divide by four
    for (int k = 1; k <= 8; k++) begin
      @(negedge mclk);
      check(mclkDiv4 == k[1], "R1 mclkDiv4", int'(mclkDiv4), int'(k[1]));
    end
    // R9 before any burst outputs stay low
    for (int b = 0; b < 4; b++) begin
      driveBit(1'b1, 1'b1, 1'b0, 1'b0);
      check(!wck && !dataOut, "R9 idle before burst", int'({wck, dataOut}), 0);
    end
    // table: R3 R4 R5 R10 (bursts at offsets not aligned to word length)
    for (int i = 0; i < 5; i++) begin
      s = SEGS[i];
      for (int b = 0; b < int'(s[55:48]); b++) begin
        driveBit(s[47 - (b % WORD)], s[23 - (b % WORD)],
                 s[56] && b < 3, s[56] && b == 0);
      end
    end
    // R10 mid-frame restart: after the burst wck must be high
    driveBit(1'b0, 1'b1, 1'b1, 1'b1);
    check(wck == 1'b1, "R10 restart wck", int'(wck), 1);
    for (int b = 0; b < 10; b++) driveBit(b[0], ~b[0], 1'b0, 1'b0);
    // R9 reset in mid-stream
    @(negedge mclk); rstN = 1'b0;
    @(negedge mclk); @(negedge mclk);
    check({bck, wck, dataOut, mclkDiv4} == 4'b0, "R9 mid reset", int'({bck, wck, dataOut, mclkDiv4}), 0);
    rstN = 1'b1;
    mStarted = 1'b0; mWck = 1'b0; mCnt = 0; rq = '0;
    for (int b = 0; b < 5; b++) driveBit(1'b1, 1'b1, 1'b0, 1'b0);
    check(!wck && !dataOut, "R9 idle after reset", int'({wck, dataOut}), 0);
    // R3 first edge after reset counts, close edges are ignored (three burst bits)
    for (int b = 0; b < 60; b++) driveBit(b[1], b[2], b < 3, b == 0);
    finishRun();
  end
endmodule